// File: doc/BRIEF.md
# Test Pattern Inserter for a Converter Sample Stream

This block sits on the sample stream of an analog-to-digital converter and, under control of a three-bit mode code, either forwards live samples or replaces them with a synthetic word. It is placed ahead of any output bit reordering or serialisation, so the pattern it produces does not depend on the output format. Downstream logic sees the pattern exactly where it would otherwise see converter data. This lets a receiver check its link and its bit ordering without an analog signal present.

There are two synthetic patterns. The first is a fixed word. The second is an incrementing ramp. A single 18-bit pattern input plays both roles: in fixed mode it is the word sent out, and in ramp mode it is the amount added per sample. All words are MSB-aligned to an 18-bit native width. A narrower converter therefore counts by one of its own LSBs when the step is 1 for 18-bit, 4 for 16-bit or 16 for 14-bit data.

Every mode passes through one register stage. Output valid therefore tracks input valid one cycle later, whatever the mode.

Top module: `pattern_inserter`

## Requirements
- R1: While reset (active low) is asserted, and in the first cycle after it, `outValid` is 0 and `outData` is 0.
- R2: In every mode, `outValid` equals the value that `inValid` had one clock earlier.
- R3: With mode code 3'b000 (live), a sample that has `inValid` high appears unchanged on `outData` one clock later.
- R4: With mode code 3'b011 (fixed), a cycle that has `inValid` high produces `patWord` on `outData` one clock later, with bit 17 as MSB and no shift.
- R5: With mode code 3'b010 (ramp), the first valid sample after the mode becomes ramp outputs 0. Each further valid sample outputs the previous ramp value plus `patWord`.
- R6: The ramp wraps modulo 2^18.
- R7: The ramp does not advance on cycles with `inValid` low. Any cycle spent in a mode other than ramp restarts the ramp from 0.
- R8: The unused mode codes 3'b001, 3'b100, 3'b101, 3'b110 and 3'b111 behave exactly like live mode.
- R9: When `inValid` is low, `outData` keeps its previous value one clock later.
- R10: With a step of 4 (16-bit) or 16 (14-bit), the ramp keeps the bits below that resolution at zero. The MSB-aligned field advances by one per valid sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input sample strobe |
| inData | input | 18 | Converter sample, MSB-aligned |
| modeSel | input | 3 | Mode: 000 live, 010 ramp, 011 fixed, others live |
| patWord | input | 18 | Fixed word or ramp step |
| outValid | output | 1 | Output sample strobe |
| outData | output | 18 | Selected output word |

## Verification
The bench runs the ramp through gaps in the valid strobe. A design that advanced on idle cycles would show skipped values. It then leaves ramp mode and returns, which catches a design that resumes from the old count instead of 0. A large step forces wrap-around, so an accumulator that saturates or carries past 18 bits returns a wrong word. Unused codes are driven to catch a design that emits the pattern or zero for them. Idle cycles between samples catch an output that is cleared instead of held.

// File: rtl/pattern_pkg.sv
`timescale 1ns/1ps
package pattern_pkg;
  localparam int WORD_W = 18;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_LIVE  = 3'b000;
  localparam logic [MODE_W-1:0] MODE_RAMP  = 3'b010;
  localparam logic [MODE_W-1:0] MODE_FIXED = 3'b011;

  // strobes from control to datapath
  typedef struct packed {
    logic takeLive;
    logic takeFixed;
    logic takeRamp;
    logic rampClear;
  } strobe_t;
endpackage

// File: rtl/pattern_ctrl.sv
`timescale 1ns/1ps
module pattern_ctrl
  import pattern_pkg::*;
(
  input  logic              inValid,
  input  logic [MODE_W-1:0] modeSel,
  output strobe_t           strobes
);
  logic isRamp;
  logic isFixed;

  always_comb begin
    isRamp  = (modeSel == MODE_RAMP);
    isFixed = (modeSel == MODE_FIXED);
    strobes.takeRamp  = inValid && isRamp;
    strobes.takeFixed = inValid && isFixed;
    // live and every unused code share the passthrough path
    strobes.takeLive  = inValid && !isRamp && !isFixed;
    strobes.rampClear = !isRamp;
  end
endmodule

// File: rtl/pattern_datapath.sv
`timescale 1ns/1ps
module pattern_datapath
  import pattern_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] patWord,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] rampAcc;

  // ramp accumulator: holds the next word to emit, wraps naturally
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rampAcc <= '0;
    end else if (strobes.rampClear) begin
      rampAcc <= '0;
    end else if (strobes.takeRamp) begin
      rampAcc <= rampAcc + patWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= inValid;
      if (strobes.takeLive) begin
        outData <= inData;
      end else if (strobes.takeFixed) begin
        outData <= patWord;
      end else if (strobes.takeRamp) begin
        outData <= rampAcc;
      end
    end
  end
endmodule

// File: rtl/pattern_inserter.sv
`timescale 1ns/1ps
module pattern_inserter
  import pattern_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [2:0]        modeSel,
  input  logic [DATA_W-1:0] patWord,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  strobe_t strobes;

  pattern_ctrl u_ctrl (
    .inValid (inValid),
    .modeSel (modeSel),
    .strobes (strobes)
  );

  pattern_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inValid  (inValid),
    .inData   (inData),
    .patWord  (patWord),
    .outValid (outValid),
    .outData  (outData)
  );
endmodule

// File: rtl/pattern_inserter_chk.sv
`timescale 1ns/1ps
module pattern_inserter_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic [2:0]        modeSel,
  input logic [DATA_W-1:0] patWord,
  input logic              outValid,
  input logic [DATA_W-1:0] outData
);
  logic prevRamp;
  always_ff @(posedge clk) begin
    if (!rstN) prevRamp <= 1'b0;
    else       prevRamp <= (modeSel == 3'b010);
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> outValid == $past(inValid));

  // R3
  live_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel == 3'b000) |=> outData == $past(inData));

  // R4
  fixed_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel == 3'b011) |=> outData == $past(patWord));

  // R5
  ramp_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel == 3'b010 && !prevRamp) |=> outData == '0);

  // R8
  unused_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel != 3'b000 && modeSel != 3'b010 && modeSel != 3'b011)
      |=> outData == $past(inData));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outData));
endmodule

bind pattern_inserter pattern_inserter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inData   (inData),
  .modeSel  (modeSel),
  .patWord  (patWord),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/pattern_inserter_test.sv
`timescale 1ns/1ps
module pattern_inserter_test;
  localparam int W = 18;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic [2:0] modeSel = 3'b000;
  logic [W-1:0] patWord = '0;
  logic outValid;
  logic [W-1:0] outData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic         v;
    logic [W-1:0] d;
    string        tag;
    bit           lowCheck;
  } exp_t;
  exp_t expQ[$];

  logic [W-1:0] modelRamp = '0;
  logic [W-1:0] modelOut = '0;

  always #4 clk = ~clk;

  pattern_inserter uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .modeSel(modeSel), .patWord(patWord), .outValid(outValid), .outData(outData)
  );

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] expv);
    testsRun++;
    if (act !== expv) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(input logic [2:0] m, input logic [W-1:0] p,
                       input logic [W-1:0] d, input logic v, input string tag,
                       input bit lowCheck = 1'b0);
    exp_t e;
    @(negedge clk);
    modeSel = m; patWord = p; inData = d; inValid = v;
    if (m == 3'b010) begin
      if (v) begin
        modelOut = modelRamp;
        modelRamp = (modelRamp + p) & MASK;
      end
    end else begin
      modelRamp = '0;
      if (v) modelOut = (m == 3'b011) ? p : d;
    end
    e.v = v; e.d = modelOut; e.tag = tag; e.lowCheck = lowCheck;
    expQ.push_back(e);
  endtask

  // monitor: compares after each edge that consumed a queued item
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(e.tag, {outValid, outData}, {e.v, e.d});
        if (e.lowCheck) check("R10 low bits", {1'b0, outData & 18'h0000F}, '0);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {outValid, outData}, '0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;
    check("R1 post-reset", {outValid, outData}, '0);

    // R3 live, with R9 gaps and R2 valid tracking
    drive(3'b000, 18'h0, 18'h2A5A5, 1'b1, "R3 live");
    drive(3'b000, 18'h0, 18'h3FFFF, 1'b1, "R3 live");
    drive(3'b000, 18'h0, 18'h11111, 1'b0, "R9 hold");
    drive(3'b000, 18'h0, 18'h22222, 1'b0, "R2 idle");
    drive(3'b000, 18'h0, 18'h00001, 1'b1, "R3 live");

    // R4 fixed
    drive(3'b011, 18'h2B3C4, 18'h12345, 1'b1, "R4 fixed");
    drive(3'b011, 18'h20000, 18'h12345, 1'b1, "R4 fixed msb");
    drive(3'b011, 18'h1FFFF, 18'h12345, 1'b0, "R9 hold fixed");

    // R5 ramp step 1, R7 gaps
    for (int i = 0; i < 5; i++) drive(3'b010, 18'h1, 18'h0, 1'b1, "R5 ramp");
    drive(3'b010, 18'h1, 18'h0, 1'b0, "R7 no advance");
    drive(3'b010, 18'h1, 18'h0, 1'b0, "R7 no advance");
    drive(3'b010, 18'h1, 18'h0, 1'b1, "R7 resume");

    // R7 leave and re-enter restarts at zero
    drive(3'b000, 18'h1, 18'h3ABCD, 1'b0, "R7 leave");
    drive(3'b010, 18'h1, 18'h0, 1'b1, "R7 restart");
    drive(3'b010, 18'h1, 18'h0, 1'b1, "R7 restart");

    // R6 wrap with large step
    drive(3'b000, 18'h0, 18'h0, 1'b0, "R6 prep");
    for (int i = 0; i < 6; i++) drive(3'b010, 18'h10000, 18'h0, 1'b1, "R6 wrap");

    // R10 16-bit and 14-bit steps
    drive(3'b000, 18'h0, 18'h0, 1'b0, "R10 prep");
    for (int i = 0; i < 4; i++) drive(3'b010, 18'h4, 18'h0, 1'b1, "R10 step4");
    drive(3'b000, 18'h0, 18'h0, 1'b0, "R10 prep");
    for (int i = 0; i < 4; i++) drive(3'b010, 18'h10, 18'h0, 1'b1, "R10 step16", 1'b1);

    // R8 unused codes pass live data
    drive(3'b001, 18'h15555, 18'h0F0F0, 1'b1, "R8 code001");
    drive(3'b100, 18'h15555, 18'h30303, 1'b1, "R8 code100");
    drive(3'b101, 18'h15555, 18'h0A0A0, 1'b1, "R8 code101");
    drive(3'b110, 18'h15555, 18'h1C1C1, 1'b1, "R8 code110");
    drive(3'b111, 18'h15555, 18'h25252, 1'b1, "R8 code111");
    drive(3'b111, 18'h15555, 18'h3FFFF, 1'b0, "R9 hold unused");

    @(negedge clk); inValid = 1'b0;
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule